// File: doc/BRIEF.md
# Multi-Core Ping-Pong Sample Buffer Read Arbiter

A group of parallel detection cores shares one single-port sample memory. The memory is split into two banks. One bank holds the return being processed while the other is refilled. Each core scans its own stretch of range cells. Neighbouring stretches share a margin equal to the reference window, so a cell near a stretch boundary still sees a full neighbourhood. This block sits between the cores and the memory. It grants one pending core per cycle, drives that core's address onto the memory port, and one cycle later returns the word to that core with a valid strobe. It then advances the core's pointer.

A core raises its request line for one or more cycles. The block latches the request into a per-core flag and clears the flag when the read is issued. Pending flags are served in round-robin order. A core whose pointer has moved past the end of its stretch is exhausted. Its requests are then dropped until the next bank swap. A bank-swap strobe flips the bank being read and rewinds every pointer to the start of its stretch.

Top module: `pp_read_arbiter`

## Requirements
- R1: After reset, no valid strobe and no memory read are asserted. No core is exhausted, the read bank is 0 and every pointer sits at the start of its stretch.
- R2: At most one memory read is issued per cycle, and at most one core's valid strobe is high in any cycle.
- R3: A read issued in cycle t raises exactly the granted core's valid strobe in cycle t+1. The data on that core's lane is the memory word at the issued address; the memory has one cycle of read latency. With no read in cycle t, no valid is raised in t+1.
- R4: A request is held in a flag until it is served. Each served flag yields exactly one read. Further request cycles while the flag is still pending merge into it and give no extra read.
- R5: Among eligible pending cores, the grant goes to the first one found when stepping upward cyclically from the core granted last. Core 0 is reached first after reset.
- R6: Core i reads cells start(i)=max(0, i*CHUNK-OVERLAP) up to end(i)=min(CELLS-1, (i+1)*CHUNK+OVERLAP-1) in ascending order, one cell per read. Once past end(i), its exhausted bit is high and stays high until a swap, and its requests produce no read.
- R7: In a cycle with the swap strobe high, no read is issued. At the following edge the read bank toggles, all pointers return to their start cells and the exhausted bits clear. Flags that were pending are kept and are served from the new bank.
- R8: The memory address is the bank bit as the most significant bit, followed by the cell index in clog2(CELLS) bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coreReq | input | NUM_CORES | Per-core read request, one bit per core |
| bankSwap | input | 1 | Strobe that flips the bank read and rewinds the pointers |
| coreValid | output | NUM_CORES | Per-core data-valid strobe |
| coreData | output | NUM_CORES*DATA_W | Per-core data lanes, lane i at bits i*DATA_W and up |
| coreDone | output | NUM_CORES | Per-core stretch-exhausted indication |
| memRdEn | output | 1 | Memory read enable |
| memAddr | output | 1+clog2(CELLS) | Memory read address: {bank, cell} |
| memRdData | input | DATA_W | Memory read data, one cycle after the address |

## Verification
The swap strobe and a grant can fall in the same cycle. This happens when a core's flag becomes pending in the very cycle the swap is applied. The bench provokes this in three ways: it pulses one core's request and swaps on the next cycle, it holds a request across a swap that lasts two cycles, and it swaps in the middle of a run where every core requests continuously. It judges the outcome from the data words. The retained read must return the first cell of the new bank, and exactly once. No read may come back for the swap cycle itself. The per-stretch read counts must restart cleanly.

// File: rtl/pp_arb_pkg.sv
package pp_arb_pkg;

  localparam int IDX_W = 8;

  typedef struct packed {
    logic             swap;
    logic             grantVld;
    logic [IDX_W-1:0] grantIdx;
  } arbStrobe_t;

  function automatic int chunkStart(input int idx, input int chunk, input int overlap);
    int s;
    s = idx * chunk - overlap;
    return (s < 0) ? 0 : s;
  endfunction

  function automatic int chunkEnd(input int idx, input int chunk, input int overlap,
                                  input int cells);
    int e;
    e = (idx + 1) * chunk + overlap - 1;
    return (e > cells - 1) ? cells - 1 : e;
  endfunction

endpackage

// File: rtl/pp_arb_ctrl.sv
module pp_arb_ctrl
  import pp_arb_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] coreReq,
  input  logic [NUM_CORES-1:0] coreDone,
  input  logic                 bankSwap,
  output arbStrobe_t           strobe
);

  localparam int SELW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [NUM_CORES-1:0] reqFlag;
  logic [NUM_CORES-1:0] eligible;
  logic [NUM_CORES-1:0] grantMask;
  logic [SELW-1:0]      lastIdx;
  logic [SELW-1:0]      pick;
  logic                 found;
  logic                 grantNow;

  assign eligible = reqFlag & ~coreDone;

  // Cyclic search upward from the core granted last
  always_comb begin
    int cand;
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_CORES; k++) begin
      cand = (int'(lastIdx) + k) % NUM_CORES;
      if (!found && eligible[cand]) begin
        found = 1'b1;
        pick  = SELW'(cand);
      end
    end
  end

  assign grantNow = found & ~bankSwap;

  always_comb begin
    grantMask = '0;
    if (grantNow) grantMask[pick] = 1'b1;
  end

  assign strobe.swap     = bankSwap;
  assign strobe.grantVld = grantNow;
  assign strobe.grantIdx = IDX_W'(pick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqFlag <= '0;
      lastIdx <= SELW'(NUM_CORES - 1);
    end else begin
      reqFlag <= (reqFlag & ~grantMask) | (coreReq & ~coreDone);
      if (grantNow) lastIdx <= pick;
    end
  end

endmodule

// File: rtl/pp_arb_datapath.sv
module pp_arb_datapath
  import pp_arb_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CELLS     = 32,
  parameter int CHUNK     = 8,
  parameter int OVERLAP   = 2,
  parameter int DATA_W    = 16,
  localparam int CW       = $clog2(CELLS),
  localparam int AW       = CW + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  arbStrobe_t                  strobe,
  input  logic [DATA_W-1:0]           memRdData,
  output logic [NUM_CORES-1:0]        coreDone,
  output logic                        memRdEn,
  output logic [AW-1:0]               memAddr,
  output logic [NUM_CORES-1:0]        coreValid,
  output logic [NUM_CORES*DATA_W-1:0] coreData
);

  localparam int PW   = CW + 1;
  localparam int SELW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [PW-1:0]   ptr [NUM_CORES];
  logic            readBank;
  logic [SELW-1:0] sel;

  assign sel     = strobe.grantIdx[SELW-1:0];
  assign memRdEn = strobe.grantVld;
  assign memAddr = {readBank, ptr[sel][CW-1:0]};

  always_comb begin
    for (int i = 0; i < NUM_CORES; i++)
      coreDone[i] = (int'(ptr[i]) > chunkEnd(i, CHUNK, OVERLAP, CELLS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      readBank <= 1'b0;
      for (int i = 0; i < NUM_CORES; i++)
        ptr[i] <= PW'(chunkStart(i, CHUNK, OVERLAP));
    end else if (strobe.swap) begin
      readBank <= ~readBank;
      for (int i = 0; i < NUM_CORES; i++)
        ptr[i] <= PW'(chunkStart(i, CHUNK, OVERLAP));
    end else if (strobe.grantVld) begin
      ptr[sel] <= ptr[sel] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coreValid <= '0;
    end else begin
      coreValid <= '0;
      if (strobe.grantVld) coreValid[sel] <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : gLane
    assign coreData[g*DATA_W +: DATA_W] = memRdData;
  end

endmodule

// File: rtl/pp_read_arbiter.sv
module pp_read_arbiter
  import pp_arb_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CELLS     = 32,
  parameter int CHUNK     = 8,
  parameter int OVERLAP   = 2,
  parameter int DATA_W    = 16,
  localparam int AW       = $clog2(CELLS) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES-1:0]        coreReq,
  input  logic                        bankSwap,
  output logic [NUM_CORES-1:0]        coreValid,
  output logic [NUM_CORES*DATA_W-1:0] coreData,
  output logic [NUM_CORES-1:0]        coreDone,
  output logic                        memRdEn,
  output logic [AW-1:0]               memAddr,
  input  logic [DATA_W-1:0]           memRdData
);

  arbStrobe_t strobe;

  pp_arb_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .coreReq  (coreReq),
    .coreDone (coreDone),
    .bankSwap (bankSwap),
    .strobe   (strobe)
  );

  pp_arb_datapath #(
    .NUM_CORES (NUM_CORES),
    .CELLS     (CELLS),
    .CHUNK     (CHUNK),
    .OVERLAP   (OVERLAP),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .memRdData (memRdData),
    .coreDone  (coreDone),
    .memRdEn   (memRdEn),
    .memAddr   (memAddr),
    .coreValid (coreValid),
    .coreData  (coreData)
  );

endmodule

// File: rtl/pp_read_arbiter_chk.sv
module pp_read_arbiter_chk #(
  parameter int NUM_CORES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bankSwap,
  input logic                 memRdEn,
  input logic [NUM_CORES-1:0] coreValid,
  input logic [NUM_CORES-1:0] coreDone
);

  AST_ONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(coreValid)); // R2

  AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |=> (coreValid != '0)); // R3

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !memRdEn |=> (coreValid == '0)); // R3

  AST_SWAP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bankSwap |-> !memRdEn); // R7

  AST_SWAP_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    bankSwap |=> (coreDone == '0)); // R7

  for (genvar g = 0; g < NUM_CORES; g++) begin : gDone
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (coreDone[g] && !bankSwap) |=> coreDone[g]); // R6
  end

endmodule

bind pp_read_arbiter pp_read_arbiter_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bankSwap  (bankSwap),
  .memRdEn   (memRdEn),
  .coreValid (coreValid),
  .coreDone  (coreDone)
);

// File: tb/pp_read_arbiter_tb.sv
module pp_read_arbiter_tb;

  localparam int NC = 4;
  localparam int L  = 32;
  localparam int C  = 8;
  localparam int W  = 2;
  localparam int DW = 16;
  localparam int AW = $clog2(L) + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC-1:0]     coreReq = '0;
  logic              bankSwap = 1'b0;
  logic [NC-1:0]     coreValid;
  logic [NC*DW-1:0]  coreData;
  logic [NC-1:0]     coreDone;
  logic              memRdEn;
  logic [AW-1:0]     memAddr;
  logic [DW-1:0]     memRdData = '0;

  int checks = 0;
  int fails  = 0;
  int expPtr [NC];
  int cnt    [NC];
  int expBank = 0;
  int lastSeen = NC - 1;
  bit rrMode = 1'b0;
  bit running = 1'b0;
  bit ended = 1'b0;
  int cycles = 0;

  always #4 clk = ~clk;

  pp_read_arbiter #(.NUM_CORES(NC), .CELLS(L), .CHUNK(C), .OVERLAP(W), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .coreReq(coreReq), .bankSwap(bankSwap),
    .coreValid(coreValid), .coreData(coreData), .coreDone(coreDone),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData)
  );

  function automatic logic [DW-1:0] memWord(input int a);
    return DW'(a * 37 + 5);
  endfunction

  function automatic int sExp(input int i);
    return (i * C - W < 0) ? 0 : i * C - W;
  endfunction

  function automatic int eExp(input int i);
    return ((i + 1) * C + W - 1 > L - 1) ? L - 1 : (i + 1) * C + W - 1;
  endfunction

  // Memory model with one cycle of read latency
  always @(posedge clk) memRdData <= memWord(int'(memAddr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic resetExp();
    for (int i = 0; i < NC; i++) begin
      expPtr[i] = sExp(i);
      cnt[i] = 0;
    end
  endtask

  function automatic bit allDoneExp();
    for (int i = 0; i < NC; i++) if (expPtr[i] <= eExp(i)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doSwap();
    bankSwap = 1'b1;
    step(1);
    bankSwap = 1'b0;
    expBank ^= 1;
    resetExp();
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Scoreboard and monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      chk($onehot0(coreValid), "R2 single valid", $countones(coreValid), 1);
      if (memRdEn)
        chk(int'(memAddr[AW-1]) == expBank, "R8 bank bit", int'(memAddr[AW-1]), expBank);
      for (int i = 0; i < NC; i++) begin
        if (coreValid[i]) begin
          int a;
          a = expBank * L + expPtr[i];
          chk(coreData[i*DW +: DW] == memWord(a), "R3 lane data",
              int'(coreData[i*DW +: DW]), int'(memWord(a)));
          chk(expPtr[i] <= eExp(i), "R6 read inside stretch", expPtr[i], eExp(i));
          if (rrMode) begin
            int nx;
            nx = -1;
            for (int k = 1; k <= NC; k++) begin
              int c;
              c = (lastSeen + k) % NC;
              if (nx < 0 && expPtr[c] <= eExp(c)) nx = c;
            end
            chk(i == nx, "R5 round-robin order", i, nx);
          end
          lastSeen = i;
          expPtr[i]++;
          cnt[i]++;
        end
      end
      for (int i = 0; i < NC; i++)
        chk(coreDone[i] == (expPtr[i] > eExp(i)), "R6 exhausted bit",
            int'(coreDone[i]), int'(expPtr[i] > eExp(i)));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !ended) begin
      chk(1'b0, "watchdog", cycles, 20000);
      finishRun();
    end
  end

  initial begin
    resetExp();
    step(3);
    // R1: quiet during and after reset
    chk(coreValid == '0, "R1 valid in reset", int'(coreValid), 0);
    rst_n = 1'b1;
    step(1);
    chk(coreValid == '0, "R1 valid after reset", int'(coreValid), 0);
    chk(memRdEn == 1'b0, "R1 no read after reset", int'(memRdEn), 0);
    chk(coreDone == '0, "R1 none exhausted", int'(coreDone), 0);
    running = 1'b1;

    // R4: one pulse per core gives one read from its start cell
    for (int i = 0; i < NC; i++) begin
      coreReq[i] = 1'b1;
      step(1);
      coreReq = '0;
      step(4);
      chk(cnt[i] == 1, "R4 one read per pulse", cnt[i], 1);
      chk(expPtr[i] == sExp(i) + 1, "R1 start cell", expPtr[i], sExp(i) + 1);
    end

    // R5/R6: all cores request continuously until every stretch is read
    rrMode = 1'b1;
    coreReq = '1;
    while (!allDoneExp()) step(1);
    step(6);
    for (int i = 0; i < NC; i++)
      chk(cnt[i] == eExp(i) - sExp(i) + 1, "R6 reads per stretch", cnt[i], eExp(i) - sExp(i) + 1);
    chk(cnt[0] == 10 && cnt[3] == 10 && cnt[1] == 12, "R6 clamped edges", cnt[0], 10);
    coreReq = '0;
    step(2);
    chk(coreValid == '0, "R6 exhausted requests ignored", int'(coreValid), 0);
    rrMode = 1'b0;

    // R7: swap rewinds, then a pending flag collides with a swap
    doSwap();
    step(1);
    chk(coreDone == '0, "R7 exhausted cleared", int'(coreDone), 0);
    coreReq[2] = 1'b1;
    step(1);
    coreReq = '0;
    doSwap();
    step(4);
    chk(cnt[2] == 1, "R7 pending flag kept across swap", cnt[2], 1);
    chk(expBank == 0, "R7 bank toggled twice", expBank, 0);

    // R4: repeated request while the flag is pending merges (two-cycle swap)
    coreReq[1] = 1'b1;
    bankSwap = 1'b1;
    step(2);
    coreReq = '0;
    bankSwap = 1'b0;
    resetExp();
    step(5);
    chk(cnt[1] == 1, "R4 merged request", cnt[1], 1);
    chk(cnt[0] == 0 && cnt[2] == 0 && cnt[3] == 0, "R4 no stray reads", cnt[0] + cnt[2] + cnt[3], 0);

    // R7: swap in the middle of a full-rate run
    rrMode = 1'b1;
    coreReq = '1;
    step(9);
    doSwap();
    while (!allDoneExp()) step(1);
    step(6);
    for (int i = 0; i < NC; i++)
      chk(cnt[i] == eExp(i) - sExp(i) + 1, "R7 full stretch after mid swap", cnt[i], eExp(i) - sExp(i) + 1);
    coreReq = '0;
    step(3);
    running = 1'b0;
    finishRun();
  end

endmodule